// File: doc/BRIEF.md
# Address-Programmable Digital Delay Line

This block delays a single-bit, clock-synchronous signal by a number of clock cycles chosen with a small address. The delay has two parts. The first is a fixed base latency. The second is the address value multiplied by a fixed step. Both parts are elaboration-time parameters counted in cycles. The delayed bit is driven on a true output and on a complementary output. An active-low enable controls the outputs. When the enable is released (driven high), the true output is held low and the complementary output is held high.

The address is not captured. The tap follows the address pins on every cycle, so a change of address shows up at the next clock edge. The internal history keeps shifting while the outputs are forced. Bits that are still stored can therefore reach the outputs after a re-enable, or after an address increase. Two registered flags report when it is safe to take either action. One flag covers the window the current address exposes. The other covers the part of that window beyond the base latency.

Top module: `prog_delay_line`

## Requirements
- R1: With `en_n` low, `dout` after rising edge n equals the `din` value sampled at rising edge n−D, where D = BASE_DLY + addr·STEP_DLY. `addr` is taken as an unsigned number. Samples taken while `rst` was high count as 0.
- R2: The latency of a single-cycle pulse is strictly larger for every larger address, over all 2^ADDR_W addresses.
- R3: `dout_n` is always the complement of `dout` after the first reset.
- R4: After any rising edge where `en_n` is high (and `rst` low), `dout` is 0 and `dout_n` is 1.
- R5: The address is used live. The tap used at edge n is selected by the `addr` value present at edge n, including the first edge after a change.
- R6: The history keeps shifting while `en_n` is high. A bit that entered before a disable and reaches the selected tap after re-enable appears at `dout`.
- R7: `reen_ok` after edge n is 1 exactly when every `din` sample from edges n−1 down to n−D is 0, with D taken from `addr` at edge n.
- R8: `step_ok` after edge n is 1 exactly when every `din` sample from edges n−BASE_DLY down to n−D is 0.
- R9: A synchronous active-high `rst` clears the history. After a reset edge, `dout`=0, `dout_n`=1, `reen_ok`=1 and `step_ok`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 1 | Bit to be delayed, synchronous to clk |
| addr | input | ADDR_W | Delay setting, used live |
| en_n | input | 1 | Output enable, active low |
| dout | output | 1 | Delayed bit, registered |
| dout_n | output | 1 | Complement of dout, registered |
| reen_ok | output | 1 | No stored 1 within the selected delay window |
| step_ok | output | 1 | No stored 1 between base tap and selected tap |

## Verification
Two things can happen at the same clock edge: an address change and a re-enable. When they coincide, the newly chosen tap and the forced-output release act on the same cycle. The bench provokes this directly. It loads a pattern and disables the outputs for a few cycles. Then, on one negative edge, it changes `addr` and drops `en_n` together. Random runs add more cases where both inputs toggle often. A queue-based history model is compared against the design on every cycle. From the samples it holds, the model predicts both outputs and both flags, so any bit that leaks out through the new tap is judged exactly.

// File: rtl/dly_pkg.sv
package dly_pkg;
  // cycle count of the total delay for a given address
  function automatic int tap_of(input int base, input int step, input int a);
    return base + a * step;
  endfunction
endpackage

// File: rtl/dly_shift.sv
module dly_shift #(
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             din,
  output logic [DEPTH-1:0] stages
);
  // stages[i] holds the din sample of i+1 edges ago
  always_ff @(posedge clk) begin
    if (rst) stages <= '0;
    else     stages <= {stages[DEPTH-2:0], din};
  end
endmodule

// File: rtl/dly_tap_window.sv
module dly_tap_window
  import dly_pkg::*;
#(
  parameter int BASE_DLY = 3,
  parameter int STEP_DLY = 2,
  parameter int ADDR_W   = 3,
  parameter int DEPTH    = tap_of(BASE_DLY, STEP_DLY, (1 << ADDR_W) - 1)
) (
  input  logic [DEPTH-1:0]  stages,
  input  logic [ADDR_W-1:0] addr,
  output logic              tap_bit,
  output logic              busy_upto,
  output logic              busy_step
);
  localparam int NTAP = 1 << ADDR_W;

  logic [NTAP-1:0] taps;
  logic [NTAP-1:0] any_upto;
  logic [NTAP-1:0] any_step;

  for (genvar a = 0; a < NTAP; a++) begin : g_tap
    localparam int HI = tap_of(BASE_DLY, STEP_DLY, a) - 1;
    assign taps[a]     = stages[HI];
    assign any_upto[a] = |stages[HI:0];
    assign any_step[a] = |stages[HI:BASE_DLY-1];
  end

  assign tap_bit   = taps[addr];
  assign busy_upto = any_upto[addr];
  assign busy_step = any_step[addr];
endmodule

// File: rtl/prog_delay_line.sv
module prog_delay_line
  import dly_pkg::*;
#(
  parameter int BASE_DLY = 3,
  parameter int STEP_DLY = 2,
  parameter int ADDR_W   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              din,
  input  logic [ADDR_W-1:0] addr,
  input  logic              en_n,
  output logic              dout,
  output logic              dout_n,
  output logic              reen_ok,
  output logic              step_ok
);
  localparam int DEPTH = tap_of(BASE_DLY, STEP_DLY, (1 << ADDR_W) - 1);

  if (BASE_DLY < 1 || STEP_DLY < 1) begin : g_bad_param
    $error("prog_delay_line: BASE_DLY and STEP_DLY must both be at least 1");
  end

  logic [DEPTH-1:0] stages;
  logic             tap_bit;
  logic             busy_upto;
  logic             busy_step;

  dly_shift #(.DEPTH(DEPTH)) u_shift (
    .clk    (clk),
    .rst    (rst),
    .din    (din),
    .stages (stages)
  );

  dly_tap_window #(
    .BASE_DLY (BASE_DLY),
    .STEP_DLY (STEP_DLY),
    .ADDR_W   (ADDR_W),
    .DEPTH    (DEPTH)
  ) u_win (
    .stages    (stages),
    .addr      (addr),
    .tap_bit   (tap_bit),
    .busy_upto (busy_upto),
    .busy_step (busy_step)
  );

  // output stage is the last of the D registers on the path
  always_ff @(posedge clk) begin
    if (rst) begin
      dout    <= 1'b0;
      dout_n  <= 1'b1;
      reen_ok <= 1'b1;
      step_ok <= 1'b1;
    end else begin
      dout    <= ~en_n & tap_bit;
      dout_n  <= en_n | ~tap_bit;
      reen_ok <= ~busy_upto;
      step_ok <= ~busy_step;
    end
  end
endmodule

// File: rtl/prog_delay_line_chk.sv
module prog_delay_line_chk (
  input logic clk,
  input logic rst,
  input logic en_n,
  input logic dout,
  input logic dout_n,
  input logic reen_ok,
  input logic step_ok
);
  assert_outputs_complement_R3: assert property (@(posedge clk) disable iff (rst)
    dout_n == !dout);

  assert_disable_forces_R4: assert property (@(posedge clk) disable iff (rst)
    en_n |=> (!dout && dout_n));

  assert_rise_needs_enable_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(dout) |-> $past(!en_n));

  assert_reset_state_R9: assert property (@(posedge clk)
    rst |=> (!dout && dout_n && reen_ok && step_ok));

  // the step window is part of the re-enable window (R7, R8)
  assert_flag_nesting_R8: assert property (@(posedge clk) disable iff (rst)
    reen_ok |-> step_ok);
endmodule

bind prog_delay_line prog_delay_line_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .en_n    (en_n),
  .dout    (dout),
  .dout_n  (dout_n),
  .reen_ok (reen_ok),
  .step_ok (step_ok)
);

// File: tb/prog_delay_line_tb_top.sv
module prog_delay_line_tb_top;
  localparam int BASE = 3;
  localparam int STEP = 2;
  localparam int AW   = 3;
  localparam int NA   = 1 << AW;
  localparam int DMAX = BASE + (NA - 1) * STEP;

  logic clk = 1'b0;
  logic rst, din, en_n;
  logic [AW-1:0] addr;
  logic dout, dout_n, reen_ok, step_ok;

  always #2 clk = ~clk;

  prog_delay_line #(.BASE_DLY(BASE), .STEP_DLY(STEP), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst), .din(din), .addr(addr), .en_n(en_n),
    .dout(dout), .dout_n(dout_n), .reen_ok(reen_ok), .step_ok(step_ok)
  );

  int  n_vec  = 0;
  int  n_fail = 0;
  bit  hq[$];
  bit  mv = 0;
  bit  e_do, e_dn, e_ro, e_so, e_rst, e_dis;

  // reference model: queue of past din samples, newest at the front
  always @(posedge clk) begin
    if (rst) begin
      hq.delete();
      for (int i = 0; i < DMAX; i++) hq.push_back(1'b0);
      e_do = 0; e_dn = 1; e_ro = 1; e_so = 1; e_rst = 1; e_dis = 0;
    end else if (hq.size() == DMAX) begin
      int d;
      d = BASE + int'(addr) * STEP;
      e_rst = 0;
      e_dis = en_n;
      e_do = !en_n && hq[d-1];
      e_dn = !e_do;
      e_ro = 1; e_so = 1;
      for (int i = 0; i < d; i++) begin
        if (hq[i]) e_ro = 0;
        if (hq[i] && i >= BASE - 1) e_so = 0;
      end
      hq.push_front(din);
      void'(hq.pop_back());
    end
    mv = (hq.size() == DMAX);
  end

  task automatic fail_line(string tag, string sig, bit got, bit exp);
    n_fail++;
    $display("FAIL %s %s got %0b expected %0b at %0t", tag, sig, got, exp, $time);
  endtask

  always @(negedge clk) begin
    if (mv) begin
      n_vec++;
      if (e_rst) begin
        if (dout !== 1'b0 || dout_n !== 1'b1 || reen_ok !== 1'b1 || step_ok !== 1'b1) begin
          n_fail++;
          $display("FAIL R9 reset state got %0b%0b%0b%0b expected 0111",
                   dout, dout_n, reen_ok, step_ok);
        end
      end else begin
        if (dout !== e_do) fail_line(e_dis ? "R4" : "R1 R5 R6", "dout", dout, e_do);
        if (dout_n !== e_dn) fail_line(e_dis ? "R4" : "R3", "dout_n", dout_n, e_dn);
        if (reen_ok !== e_ro) fail_line("R7", "reen_ok", reen_ok, e_ro);
        if (step_ok !== e_so) fail_line("R8", "step_ok", step_ok, e_so);
      end
    end
  end

  // pulse latency in edges; optional disable window while the pulse is stored
  task automatic pulse_latency(output int lat, input int dis_on, input int dis_off);
    int cnt = 0;
    din = 1'b1;
    lat = -1;
    while (cnt < DMAX + 6) begin
      @(posedge clk);
      cnt++;
      @(negedge clk);
      din = 1'b0;
      if (cnt == dis_on)  en_n = 1'b1;
      if (cnt == dis_off) en_n = 1'b0;
      if (dout === 1'b1) begin
        lat = cnt - 1;
        break;
      end
    end
  endtask

  task automatic idle(int n);
    din = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  bit done = 0;

  initial begin
    int prev;
    int lat;
    rst = 1'b1; din = 1'b0; en_n = 1'b0; addr = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R2: latency per address, strictly growing
    prev = 0;
    for (int a = 0; a < NA; a++) begin
      addr = AW'(a);
      idle(DMAX + 2);
      pulse_latency(lat, -1, -1);
      n_vec++;
      if (lat != BASE + a * STEP || lat <= prev) begin
        n_fail++;
        $display("FAIL R2 addr %0d latency got %0d expected %0d", a, lat, BASE + a * STEP);
      end
      prev = lat;
    end

    // R6: pulse stored during a disable still emerges after re-enable
    addr = AW'(NA - 1);
    idle(DMAX + 2);
    pulse_latency(lat, 4, 8);
    n_vec++;
    if (lat != DMAX) begin
      n_fail++;
      $display("FAIL R6 stored pulse latency got %0d expected %0d", lat, DMAX);
    end

    // address change and re-enable on the same edge (R5, R6)
    for (int a = 0; a < NA; a++) begin
      addr = AW'(a);
      for (int k = 0; k < DMAX; k++) begin
        din = ((k + a) % 3) == 0;
        @(negedge clk);
      end
      din = 1'b0;
      en_n = 1'b1;
      repeat (4) @(negedge clk);
      addr = AW'(NA - 1 - a);
      en_n = 1'b0;
      idle(DMAX + 3);
    end

    // random traffic with live address, enable toggles and rare resets
    for (int c = 0; c < 4000; c++) begin
      din = ($urandom % 3) == 0;
      if ($urandom % 12 == 0) addr = AW'($urandom);
      if ($urandom % 25 == 0) en_n = ~en_n;
      rst = ($urandom % 600) == 0;
      @(negedge clk);
    end
    rst = 1'b0; en_n = 1'b0;
    idle(DMAX + 2);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end
endmodule